// File: doc/BRIEF.md
# Test Pattern Address Sequencer

This block generates the address of a pattern memory in which every vector word also carries a flow-control opcode. Each cycle it takes the instruction word that the memory returns for the current address, decodes it, and registers the next address. The address therefore changes exactly once per clock, and a vector's timing never depends on the flow taken to reach it. The pattern memory and the pin electronics sit outside the block.

Flow control covers several cases:
- counted loops, and loops that repeat until a comparator match, with a timeout;
- early exit from a loop and skip to the next iteration;
- unconditional jumps, and branches on a pass/fail or bin flag;
- nested subroutine calls and returns.

Two LIFO stacks of fixed depth hold the open loop frames and the return addresses. A stop opcode raises a done indication and parks the sequencer until a handler acknowledges it. A stack overflow or underflow parks it for good and latches an error.

Top module: `pat_addr_seq`

## Requirements
- R1: A counted-loop opcode with count N (0 treated as 1) runs the following block, up to and including the matching end-loop opcode, N times, and then continues at the address after the end-loop.
- R2: A match-loop opcode repeats its block. When the match input is high at the end-loop, the sequencer leaves the loop at the next address without setting the timeout flag.
- R3: If a match loop's count (its timeout, 0 treated as 1) runs out without a match, the sequencer falls through and sets timeout_o. timeout_o then stays high until reset.
- R4: A jump opcode loads its target operand into the address on the next cycle.
- R5: A break opcode pops the innermost loop frame and continues at its target operand. An enclosing loop keeps its own count.
- R6: A continue opcode counts one iteration of the innermost loop. If iterations remain it returns to the loop start. Otherwise it pops the frame and continues at its target operand.
- R7: A conditional branch goes to its target when the condition chosen by count bits [1:0] holds, and otherwise goes to the next address. The conditions are 0 = fail_i high, 1 = fail_i low, 2 = bin_i high, 3 = bin_i low.
- R8: A call pushes the address after the call and jumps to its target. A return pops the stack and jumps to the popped address. Calls nest up to the stack depth.
- R9: A stop opcode holds the address and raises done_o from the next cycle on until ack_i is seen high. The sequencer then drops done_o and resumes at the address after the stop.
- R10: A push onto a full stack (9th nested call or loop) or a pop from an empty stack does three things: the address freezes, err_o rises on the next cycle, and both stay that way until reset.
- R11: The instruction word is {opcode[35:32], target[31:16], count[15:0]}. The opcodes are 0 no-op, 1 loop, 2 end-loop, 3 match-loop, 4 jump, 5 break, 6 continue, 7 branch, 8 call, 9 return, 10 stop, and any other value is a no-op. After reset the address is 0 and done_o, err_o and timeout_o are low. Each instruction takes one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_i | input | 36 | Instruction word read at addr_o |
| match_i | input | 1 | Comparator match condition |
| fail_i | input | 1 | Pass/fail flag (1 = fail) |
| bin_i | input | 1 | Bin flag |
| ack_i | input | 1 | Handler acknowledge for stop |
| addr_o | output | 16 | Current pattern address |
| done_o | output | 1 | Pattern stopped, waiting for handler |
| err_o | output | 1 | Sticky stack overflow/underflow error |
| timeout_o | output | 1 | Sticky match-loop timeout |

## Verification
The overflow error is the hardest state to reach, because it requires eight return addresses to be held at the same time. The stimulus reaches it with a chain of calls at consecutive addresses that never return, so the stack fills in eight cycles and the ninth call must freeze the address. The break test nests one loop inside another. A correct pop then shows up at the ports: the outer loop still runs its own count and exits at the correct address.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LOOP  = 4'd1,
    OP_ENDL  = 4'd2,
    OP_MLOOP = 4'd3,
    OP_JMP   = 4'd4,
    OP_BRK   = 4'd5,
    OP_CONT  = 4'd6,
    OP_BRF   = 4'd7,
    OP_CALL  = 4'd8,
    OP_RET   = 4'd9,
    OP_STOP  = 4'd10
  } op_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_HALT = 2'd2
  } st_e;

  // Branch condition select: 0 fail, 1 pass, 2 bin set, 3 bin clear
  function automatic logic f_take(input logic [1:0] sel, input logic fail, input logic bin);
    case (sel)
      2'd0:    return fail;
      2'd1:    return !fail;
      2'd2:    return bin;
      default: return !bin;
    endcase
  endfunction

endpackage

// File: rtl/seq_lifo.sv
module seq_lifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         upd,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int IXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNW = $clog2(DEPTH + 1);

  logic [W-1:0]   mem [DEPTH];
  logic [CNW-1:0] cnt_q;
  logic [IXW-1:0] top_ix;
  logic [IXW-1:0] wr_ix;

  assign top_ix = IXW'(cnt_q - CNW'(1));
  assign wr_ix  = IXW'(cnt_q);
  assign full   = (cnt_q == CNW'(DEPTH));
  assign empty  = (cnt_q == '0);
  assign top    = mem[top_ix];

  always_ff @(posedge clk) begin
    if (push)     mem[wr_ix]  <= din;
    else if (upd) mem[top_ix] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (push) cnt_q <= cnt_q + CNW'(1);
    else if (pop)  cnt_q <= cnt_q - CNW'(1);
  end

  // R10
  lifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R10
  lifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) (pop || upd) |-> !empty);
  // R8
  lifo_one_op_chk: assert property (@(posedge clk) disable iff (!rst_n) $countones({push, pop, upd}) <= 1);

endmodule

// File: rtl/seq_next.sv
module seq_next
  import seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  localparam int LFW = 1 + AW + CW
) (
  input  op_e            op,
  input  logic [AW-1:0]  pc,
  input  logic [AW-1:0]  tgt,
  input  logic [CW-1:0]  cnt,
  input  logic [LFW-1:0] lf_top,
  input  logic           lf_empty,
  input  logic           lf_full,
  input  logic [AW-1:0]  rf_top,
  input  logic           rf_empty,
  input  logic           rf_full,
  input  logic           match_i,
  input  logic           fail_i,
  input  logic           bin_i,
  output logic [AW-1:0]  nxt_pc,
  output logic           l_push,
  output logic           l_pop,
  output logic           l_upd,
  output logic [LFW-1:0] l_wdata,
  output logic           r_push,
  output logic           r_pop,
  output logic [AW-1:0]  r_wdata,
  output logic           evt_stop,
  output logic           evt_err,
  output logic           evt_tmo
);
  function automatic logic [AW-1:0] f_inc(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [CW-1:0] f_trip(input logic [CW-1:0] c);
    return (c == '0) ? CW'(1) : c;
  endfunction

  function automatic logic f_last(input logic [CW-1:0] rem);
    return rem <= CW'(1);
  endfunction

  logic          lf_kind;
  logic [AW-1:0] lf_start;
  logic [CW-1:0] lf_rem;
  logic [AW-1:0] exit_pc;

  assign {lf_kind, lf_start, lf_rem} = lf_top;
  assign exit_pc = (op == OP_ENDL) ? f_inc(pc) : tgt;
  assign r_wdata = f_inc(pc);

  always_comb begin
    nxt_pc   = f_inc(pc);
    l_push   = 1'b0;
    l_pop    = 1'b0;
    l_upd    = 1'b0;
    l_wdata  = {(op == OP_MLOOP), f_inc(pc), f_trip(cnt)};
    r_push   = 1'b0;
    r_pop    = 1'b0;
    evt_stop = 1'b0;
    evt_err  = 1'b0;
    evt_tmo  = 1'b0;
    case (op)
      OP_LOOP, OP_MLOOP: begin
        if (lf_full) begin evt_err = 1'b1; nxt_pc = pc; end
        else l_push = 1'b1;
      end
      OP_ENDL, OP_CONT: begin
        if (lf_empty) begin
          evt_err = 1'b1; nxt_pc = pc;
        end else if (lf_kind && match_i) begin
          l_pop = 1'b1; nxt_pc = exit_pc;
        end else if (f_last(lf_rem)) begin
          l_pop = 1'b1; nxt_pc = exit_pc; evt_tmo = lf_kind;
        end else begin
          l_upd   = 1'b1;
          l_wdata = {lf_kind, lf_start, lf_rem - CW'(1)};
          nxt_pc  = lf_start;
        end
      end
      OP_JMP: nxt_pc = tgt;
      OP_BRK: begin
        if (lf_empty) begin evt_err = 1'b1; nxt_pc = pc; end
        else begin l_pop = 1'b1; nxt_pc = tgt; end
      end
      OP_BRF: if (f_take(cnt[1:0], fail_i, bin_i)) nxt_pc = tgt;
      OP_CALL: begin
        if (rf_full) begin evt_err = 1'b1; nxt_pc = pc; end
        else begin r_push = 1'b1; nxt_pc = tgt; end
      end
      OP_RET: begin
        if (rf_empty) begin evt_err = 1'b1; nxt_pc = pc; end
        else begin r_pop = 1'b1; nxt_pc = rf_top; end
      end
      OP_STOP: begin evt_stop = 1'b1; nxt_pc = pc; end
      default: ;
    endcase
  end

endmodule

// File: rtl/pat_addr_seq.sv
module pat_addr_seq
  import seq_pkg::*;
#(
  parameter int AW     = 16,
  parameter int CW     = 16,
  parameter int LDEPTH = 8,
  parameter int RDEPTH = 8,
  localparam int IW    = 4 + AW + CW,
  localparam int LFW   = 1 + AW + CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] instr_i,
  input  logic          match_i,
  input  logic          fail_i,
  input  logic          bin_i,
  input  logic          ack_i,
  output logic [AW-1:0] addr_o,
  output logic          done_o,
  output logic          err_o,
  output logic          timeout_o
);
  st_e           st_q;
  logic [AW-1:0] pc_q;
  logic          err_q, tmo_q;

  op_e           op;
  logic [AW-1:0] arg_tgt;
  logic [CW-1:0] arg_cnt;
  assign op      = op_e'(instr_i[IW-1 -: 4]);
  assign arg_tgt = instr_i[AW+CW-1 -: AW];
  assign arg_cnt = instr_i[CW-1:0];

  // Named internal events
  logic run_cyc;
  logic [AW-1:0] nxt_pc;
  logic l_push, l_pop, l_upd, r_push, r_pop;
  logic evt_stop, evt_err, evt_tmo;
  logic [LFW-1:0] l_wdata, lf_top;
  logic [AW-1:0]  r_wdata, rf_top;
  logic lf_full, lf_empty, rf_full, rf_empty;

  assign run_cyc = (st_q == ST_RUN);

  seq_next #(.AW(AW), .CW(CW)) u_next (
    .op(op), .pc(pc_q), .tgt(arg_tgt), .cnt(arg_cnt),
    .lf_top(lf_top), .lf_empty(lf_empty), .lf_full(lf_full),
    .rf_top(rf_top), .rf_empty(rf_empty), .rf_full(rf_full),
    .match_i(match_i), .fail_i(fail_i), .bin_i(bin_i),
    .nxt_pc(nxt_pc), .l_push(l_push), .l_pop(l_pop), .l_upd(l_upd), .l_wdata(l_wdata),
    .r_push(r_push), .r_pop(r_pop), .r_wdata(r_wdata),
    .evt_stop(evt_stop), .evt_err(evt_err), .evt_tmo(evt_tmo)
  );

  seq_lifo #(.W(LFW), .DEPTH(LDEPTH)) u_loop_stk (
    .clk(clk), .rst_n(rst_n),
    .push(run_cyc && l_push), .pop(run_cyc && l_pop), .upd(run_cyc && l_upd),
    .din(l_wdata), .top(lf_top), .full(lf_full), .empty(lf_empty)
  );

  seq_lifo #(.W(AW), .DEPTH(RDEPTH)) u_ret_stk (
    .clk(clk), .rst_n(rst_n),
    .push(run_cyc && r_push), .pop(run_cyc && r_pop), .upd(1'b0),
    .din(r_wdata), .top(rf_top), .full(rf_full), .empty(rf_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      pc_q  <= '0;
      err_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      case (st_q)
        ST_RUN: begin
          if (evt_err) begin
            st_q  <= ST_HALT;
            err_q <= 1'b1;
          end else begin
            pc_q <= nxt_pc;
            if (evt_stop) st_q <= ST_WAIT;
            if (evt_tmo)  tmo_q <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (ack_i) begin
            st_q <= ST_RUN;
            pc_q <= pc_q + AW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign addr_o    = pc_q;
  assign done_o    = (st_q == ST_WAIT);
  assign err_o     = err_q;
  assign timeout_o = tmo_q;

  // R4
  jmp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cyc && op == OP_JMP) |=> (addr_o == $past(arg_tgt)));
  // R8
  ret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cyc && op == OP_RET && !rf_empty) |=> (addr_o == $past(rf_top)));
  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ack_i) |=> (done_o && $stable(addr_o)));
  // R9
  stop_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cyc && op == OP_STOP) |=> (done_o && $stable(addr_o)));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (err_o && $stable(addr_o) && !done_o));
  // R10
  call_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cyc && op == OP_CALL && rf_full) |=> err_o);
  // R3
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> timeout_o);

endmodule

// File: tb/pat_addr_seq_bench.sv
`timescale 1ns/1ps
module pat_addr_seq_bench;
  localparam int NOP = 0, LOOP = 1, ENDL = 2, MLOOP = 3, JMP = 4, BRK = 5,
                 CONT = 6, BRF = 7, CALL = 8, RET = 9, STOP = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        match_i = 1'b0, fail_i = 1'b0, bin_i = 1'b0, ack_i = 1'b0;
  logic [35:0] prog [64];
  logic [35:0] instr_i;
  logic [15:0] addr_o;
  logic        done_o, err_o, timeout_o;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;
  assign instr_i = prog[addr_o[5:0]];

  pat_addr_seq u_pat_addr_seq (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .match_i(match_i),
    .fail_i(fail_i), .bin_i(bin_i), .ack_i(ack_i), .addr_o(addr_o),
    .done_o(done_o), .err_o(err_o), .timeout_o(timeout_o)
  );

  function automatic logic [35:0] mk(int op, int tgt, int cnt);
    return {op[3:0], tgt[15:0], cnt[15:0]};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_addr(int exp, string tag);
    check(addr_o == 16'(exp), tag, int'(addr_o), exp);
    @(negedge clk);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = '0;
    match_i = 0; fail_i = 0; bin_i = 0; ack_i = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    clear_prog();
    do_reset();
    check(addr_o == 0, "R11 reset addr", int'(addr_o), 0);
    check(!done_o && !err_o && !timeout_o, "R11 reset flags",
          int'({done_o, err_o, timeout_o}), 0);
  endtask

  task automatic t_loop_stop();
    clear_prog();
    prog[0] = mk(LOOP, 0, 3); prog[1] = mk(NOP, 0, 0);
    prog[2] = mk(ENDL, 0, 0); prog[3] = mk(STOP, 0, 0);
    do_reset();
    chk_addr(0, "R1"); chk_addr(1, "R1"); chk_addr(2, "R1"); chk_addr(1, "R1");
    chk_addr(2, "R1"); chk_addr(1, "R1"); chk_addr(2, "R1"); chk_addr(3, "R1");
    for (int i = 0; i < 3; i++) begin
      check(done_o == 1'b1, "R9 done held", int'(done_o), 1);
      chk_addr(3, "R9 hold");
    end
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    check(done_o == 1'b0, "R9 done drop", int'(done_o), 0);
    chk_addr(4, "R9 resume");
    chk_addr(5, "R11 one per cycle");
    check(!err_o, "R11 no err", int'(err_o), 0);
  endtask

  task automatic t_match_timeout();
    clear_prog();
    prog[0] = mk(MLOOP, 0, 5); prog[1] = mk(ENDL, 0, 0); prog[2] = mk(STOP, 0, 0);
    do_reset();
    chk_addr(0, "R3"); chk_addr(1, "R3"); chk_addr(1, "R3"); chk_addr(1, "R3");
    chk_addr(1, "R3");
    check(!timeout_o, "R3 no early timeout", int'(timeout_o), 0);
    chk_addr(1, "R3");
    check(addr_o == 2, "R3 fall through", int'(addr_o), 2);
    check(timeout_o, "R3 timeout set", int'(timeout_o), 1);
    repeat (3) @(negedge clk);
    check(timeout_o, "R3 timeout sticky", int'(timeout_o), 1);
  endtask

  task automatic t_match_hit();
    clear_prog();
    prog[0] = mk(MLOOP, 0, 9); prog[1] = mk(ENDL, 0, 0); prog[2] = mk(STOP, 0, 0);
    do_reset();
    chk_addr(0, "R2"); chk_addr(1, "R2");
    match_i = 1'b1;
    chk_addr(1, "R2");
    chk_addr(2, "R2 exit on match");
    check(!timeout_o, "R2 no timeout", int'(timeout_o), 0);
  endtask

  task automatic t_jump();
    clear_prog();
    prog[0] = mk(JMP, 5, 0); prog[5] = mk(NOP, 0, 0); prog[6] = mk(STOP, 0, 0);
    do_reset();
    chk_addr(0, "R4"); chk_addr(5, "R4"); chk_addr(6, "R4");
  endtask

  task automatic t_break();
    clear_prog();
    prog[0] = mk(LOOP, 0, 2); prog[1] = mk(LOOP, 0, 10); prog[2] = mk(BRK, 4, 0);
    prog[3] = mk(ENDL, 0, 0); prog[4] = mk(ENDL, 0, 0); prog[5] = mk(STOP, 0, 0);
    do_reset();
    chk_addr(0, "R5"); chk_addr(1, "R5"); chk_addr(2, "R5"); chk_addr(4, "R5");
    chk_addr(1, "R5 outer kept"); chk_addr(2, "R5"); chk_addr(4, "R5");
    chk_addr(5, "R5 outer exit");
    check(!err_o, "R5 no err", int'(err_o), 0);
  endtask

  task automatic t_continue();
    clear_prog();
    prog[0] = mk(LOOP, 0, 3); prog[1] = mk(CONT, 4, 0); prog[2] = mk(NOP, 0, 0);
    prog[3] = mk(ENDL, 0, 0); prog[4] = mk(STOP, 0, 0);
    do_reset();
    chk_addr(0, "R6"); chk_addr(1, "R6"); chk_addr(1, "R6"); chk_addr(1, "R6");
    chk_addr(4, "R6 exit");
  endtask

  task automatic t_branch(int sel, bit f, bit b, int exp);
    clear_prog();
    prog[0] = mk(BRF, 8, sel); prog[1] = mk(STOP, 0, 0); prog[8] = mk(STOP, 0, 0);
    fail_i = f; bin_i = b;
    do_reset();
    chk_addr(0, "R7");
    check(addr_o == 16'(exp), "R7 branch", int'(addr_o), exp);
  endtask

  task automatic t_call();
    clear_prog();
    prog[0] = mk(CALL, 10, 0); prog[1] = mk(STOP, 0, 0);
    prog[10] = mk(CALL, 20, 0); prog[11] = mk(RET, 0, 0); prog[20] = mk(RET, 0, 0);
    do_reset();
    chk_addr(0, "R8"); chk_addr(10, "R8"); chk_addr(20, "R8");
    chk_addr(11, "R8 inner ret"); chk_addr(1, "R8 outer ret");
  endtask

  task automatic t_overflow();
    clear_prog();
    for (int i = 0; i < 9; i++) prog[i] = mk(CALL, i + 1, 0);
    do_reset();
    for (int i = 0; i < 9; i++) chk_addr(i, "R10 fill");
    check(err_o, "R10 overflow err", int'(err_o), 1);
    repeat (3) @(negedge clk);
    check(addr_o == 8, "R10 frozen", int'(addr_o), 8);
    check(err_o && !done_o, "R10 sticky", int'({err_o, done_o}), 2);
  endtask

  task automatic t_underflow();
    clear_prog();
    prog[1] = mk(RET, 0, 0);
    do_reset();
    chk_addr(0, "R10"); chk_addr(1, "R10");
    check(err_o, "R10 underflow err", int'(err_o), 1);
    @(negedge clk);
    check(addr_o == 1, "R10 underflow frozen", int'(addr_o), 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_loop_stop();
    t_match_timeout();
    t_match_hit();
    t_jump();
    t_break();
    t_continue();
    t_branch(0, 1, 0, 8);
    t_branch(0, 0, 0, 1);
    t_branch(1, 1, 0, 1);
    t_branch(2, 0, 1, 8);
    t_branch(3, 0, 1, 1);
    t_branch(3, 0, 0, 8);
    t_call();
    t_overflow();
    t_underflow();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule